// File: doc/BRIEF.md
# Dual Down-Counting Reload Timer

The block holds two independent 32-bit down-counters behind a small synchronous register bus. Each counter decrements once per reference clock while it is enabled. When it reaches zero it expires. With auto-reload set, it reloads from its own reload register and runs periodically. With auto-reload clear, it fires once and then parks at zero. Each counter drives its own interrupt line, which pulses for one cycle on every expiry.

Both timers share one readable control register, so software changes one timer's bits with a read-modify-write and leaves the other timer alone. The live count and the reload value are written through separate registers. A one-shot delay and a periodic interval can therefore be loaded independently. Writing N-1 to both registers gives a period of N clocks. If software wants a count-up clock, it reloads 0xFFFFFFFF and inverts the count.

Top module: `dtimer_top`

## Requirements
- R1: After reset, every register reads zero and both interrupt lines are low.
- R2: The control register is at offset 0x00. Bit 0 enables timer 0, bit 1 sets auto-reload for timer 0, bit 2 enables timer 1 and bit 3 sets auto-reload for timer 1. A write replaces all four bits. Reads return these bits, with bits 31:4 reading zero.
- R3: While its enable bit is set, a counter drops by one on every clock. While its enable bit is clear, the counter holds its value.
- R4: With auto-reload set, an enabled counter that is at zero loads its reload value on the next clock. Loading N-1 into both registers therefore repeats every N clocks.
- R5: With auto-reload clear, the counter fires once on reaching zero and then stays at zero with no further interrupt. This lasts until its value register is rewritten or auto-reload is set.
- R6: Interrupt bit i (bit 0 for timer 0, bit 1 for timer 1) is high for the single cycle that follows a clock at which timer i expired.
- R7: A write to a value register loads the counter at the next clock. That write overrides the decrement and suppresses any expiry in that cycle. Reads of a value register return the live count.
- R8: With auto-reload set and reload 0xFFFFFFFF, the counter passes from 0 to 0xFFFFFFFF and carries on with 0xFFFFFFFE.
- R9: Timer 0's reload register is at 0x10 and its value register at 0x14. Timer 1's reload register is at 0x18 and its value register at 0x1C. Other offsets read zero and ignore writes.
- R10: Accesses and activity on one timer never change the other timer's count, reload value or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; counters tick on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 5 | Byte offset within the 0x20-byte window |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 2 | One-cycle expiry pulses, bit i for timer i |

## Verification
The assertions assume that bus_addr and bus_wdata are stable and defined while bus_wr is high. They also assume that a write lands in exactly one register per clock, since the bus can address only one offset at a time. The bench changes inputs only at falling edges. Each write strobe is held for exactly one rising edge. The one exception is a deliberate multi-cycle write to a value register, which exercises the expiry suppression. No reset is applied while the checks run, so the assertions' reset-relative history always starts from the cleared state.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;
  // register offsets; the slot stride is what the per-timer decode depends on
  localparam int unsigned CTRL_OFS  = 0;
  localparam int unsigned RELD_BASE = 16;
  localparam int unsigned CNT_BASE  = 20;
  localparam int unsigned SLOT_STEP = 8;
  localparam int unsigned CTRL_BITS_PER_TMR = 2;

  typedef struct packed {
    logic rearm;  // auto-reload
    logic run;    // enable
  } tmr_ctl_t;
endpackage

// File: rtl/dtimer_rstsync.sv
module dtimer_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dtimer_channel.sv
module dtimer_channel #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             run,
  input  logic             rearm,
  input  logic             reld_we,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reld,
  output logic             pulse
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] reld_q, reld_d;
  logic             parked_q, parked_d;
  logic             pulse_q, pulse_d;
  logic             at_zero, expire;

  assign at_zero = (cnt_q == '0);
  assign expire  = run && at_zero && (rearm || !parked_q) && !cnt_we;

  always_comb begin
    cnt_d    = cnt_q;
    parked_d = parked_q;
    reld_d   = reld_we ? wdata : reld_q;
    pulse_d  = expire;
    if (cnt_we) begin
      cnt_d    = wdata;
      parked_d = 1'b0;
    end else if (run) begin
      if (!at_zero) begin
        cnt_d    = cnt_q - 1'b1;
        parked_d = 1'b0;
      end else if (expire) begin
        if (rearm) cnt_d = reld_q;
        parked_d = !rearm;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reld_q   <= '0;
      parked_q <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      reld_q   <= reld_d;
      parked_q <= parked_d;
      pulse_q  <= pulse_d;
    end
  end

  assign count = cnt_q;
  assign reld  = reld_q;
  assign pulse = pulse_q;

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    run && !cnt_we && !at_zero |=> cnt_q == $past(cnt_q) - 1'b1);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !run && !cnt_we |=> $stable(cnt_q));
  // R4
  reload_take_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    run && rearm && !cnt_we && at_zero |=> cnt_q == $past(reld_q));
  // R5
  oneshot_park_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    run && !rearm && !cnt_we && at_zero |=> cnt_q == '0);
  // R6
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    pulse_q |-> $past(cnt_q) == '0 && $past(run));
  // R7
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_we |=> cnt_q == $past(wdata) && !pulse_q);
endmodule

// File: rtl/dtimer_regs.sv
module dtimer_regs
  import dtimer_pkg::*;
#(
  parameter int unsigned NUM_TMR = 2,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 5
) (
  input  logic                           clk,
  input  logic                           rst_ni,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic                           bus_wr,
  input  logic [DATA_W-1:0]              bus_wdata,
  input  logic [NUM_TMR-1:0][DATA_W-1:0] counts,
  input  logic [NUM_TMR-1:0][DATA_W-1:0] relds,
  output tmr_ctl_t [NUM_TMR-1:0]         ctl,
  output logic [NUM_TMR-1:0]             reld_we,
  output logic [NUM_TMR-1:0]             cnt_we,
  output logic [DATA_W-1:0]              bus_rdata
);
  localparam int unsigned CTL_W = NUM_TMR * CTRL_BITS_PER_TMR;

  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             ctl_sel, ctl_we;
  logic [NUM_TMR-1:0] reld_sel, cnt_sel;

  assign ctl_sel = (bus_addr == ADDR_W'(CTRL_OFS));
  assign ctl_we  = bus_wr && ctl_sel;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_dec
    assign reld_sel[i] = (bus_addr == ADDR_W'(RELD_BASE + SLOT_STEP * i));
    assign cnt_sel[i]  = (bus_addr == ADDR_W'(CNT_BASE + SLOT_STEP * i));
    assign reld_we[i]  = bus_wr && reld_sel[i];
    assign cnt_we[i]   = bus_wr && cnt_sel[i];
  end

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we) ctl_d = bus_wdata[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= ctl_d;
  end

  assign ctl = ctl_q;

  always_comb begin
    bus_rdata = '0;
    if (ctl_sel) bus_rdata = DATA_W'(ctl_q);
    for (int i = 0; i < NUM_TMR; i++) begin
      if (reld_sel[i]) bus_rdata = relds[i];
      if (cnt_sel[i])  bus_rdata = counts[i];
    end
  end

  // R2
  ctl_keep_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !ctl_we |=> $stable(ctl_q));
  // R2
  ctl_take_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ctl_we |=> ctl_q == $past(bus_wdata[CTL_W-1:0]));
  // R9
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $countones({ctl_we, reld_we, cnt_we}) <= 1);
endmodule

// File: rtl/dtimer_top.sv
module dtimer_top
  import dtimer_pkg::*;
#(
  parameter int unsigned NUM_TMR = 2,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_TMR-1:0] irq
);
  logic                           rst_sync_n;
  tmr_ctl_t [NUM_TMR-1:0]         ctl;
  logic [NUM_TMR-1:0]             reld_we, cnt_we;
  logic [NUM_TMR-1:0][DATA_W-1:0] counts, relds;

  dtimer_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dtimer_regs #(
    .NUM_TMR (NUM_TMR),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .counts    (counts),
    .relds     (relds),
    .ctl       (ctl),
    .reld_we   (reld_we),
    .cnt_we    (cnt_we),
    .bus_rdata (bus_rdata)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    dtimer_channel #(.CNT_W(DATA_W)) u_ch (
      .clk     (clk),
      .rst_ni  (rst_sync_n),
      .run     (ctl[i].run),
      .rearm   (ctl[i].rearm),
      .reld_we (reld_we[i]),
      .cnt_we  (cnt_we[i]),
      .wdata   (bus_wdata),
      .count   (counts[i]),
      .reld    (relds[i]),
      .pulse   (irq[i])
    );
  end
endmodule

// File: tb/dtimer_top_tb.sv
module dtimer_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  dtimer_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct packed {
    logic        tmr;
    logic [1:0]  mode;     // {auto-reload, enable}
    logic [31:0] reld;
    logic [31:0] start;
    logic [7:0]  wait_n;
    logic [31:0] exp_cnt;
    logic [7:0]  exp_irq;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{1'b0, 2'd1, 32'd0, 32'd5, 8'd3,  32'd2, 8'd0},
    '{1'b0, 2'd1, 32'd0, 32'd5, 8'd10, 32'd0, 8'd1},
    '{1'b1, 2'd3, 32'd3, 32'd3, 8'd12, 32'd3, 8'd3},
    '{1'b0, 2'd3, 32'd4, 32'd1, 8'd9,  32'd2, 8'd2},
    '{1'b1, 2'd3, 32'd0, 32'd0, 8'd5,  32'd0, 8'd5},
    '{1'b1, 2'd0, 32'd9, 32'd7, 8'd6,  32'd7, 8'd0},
    '{1'b0, 2'd1, 32'd0, 32'd0, 8'd4,  32'd0, 8'd1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // call at a falling edge; exactly one rising edge sees the write
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic run_cycles(input int n, input int t, output int pulses);
    pulses = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (irq[t]) pulses++;
    end
  endtask

  initial begin
    logic [31:0] v;
    int p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(5'h00, v); check("R1 ctrl", v, 32'h0);
    rd(5'h10, v); check("R1 reload0", v, 32'h0);
    rd(5'h14, v); check("R1 value0", v, 32'h0);
    rd(5'h18, v); check("R1 reload1", v, 32'h0);
    rd(5'h1C, v); check("R1 value1", v, 32'h0);
    check("R1 irq", {30'd0, irq}, 32'h0);

    // R2 control readback
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, v); check("R2 ctrl upper bits", v, 32'h0000_000F);
    wr(5'h00, 32'h0000_0000);
    rd(5'h00, v); check("R2 ctrl clear", v, 32'h0);

    // R9 map and unmapped offsets
    wr(5'h10, 32'h1234_5678);
    wr(5'h04, 32'hDEAD_BEEF);
    rd(5'h04, v); check("R9 unmapped read", v, 32'h0);
    rd(5'h10, v); check("R9 reload0 kept", v, 32'h1234_5678);
    rd(5'h00, v); check("R9 ctrl kept", v, 32'h0);

    // table walk: R3 R4 R5 R6
    foreach (VEC[i]) begin
      logic [4:0] rb;
      rb = VEC[i].tmr ? 5'h18 : 5'h10;
      wr(5'h00, 32'h0);
      wr(rb, VEC[i].reld);
      wr(rb + 5'h4, VEC[i].start);
      wr(5'h00, 32'(VEC[i].mode) << (2 * VEC[i].tmr));
      run_cycles(int'(VEC[i].wait_n), int'(VEC[i].tmr), p);
      rd(rb + 5'h4, v);
      check($sformatf("R3 R4 R5 count vec %0d", i), v, VEC[i].exp_cnt);
      check($sformatf("R6 pulses vec %0d", i), 32'(p), 32'(VEC[i].exp_irq));
    end

    // R8 full-range wrap
    wr(5'h00, 32'h0);
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h14, 32'h1);
    wr(5'h00, 32'h3);
    run_cycles(3, 0, p);
    rd(5'h14, v); check("R8 wrap value", v, 32'hFFFF_FFFE);
    check("R8 wrap pulses", 32'(p), 32'd1);

    // R5 parked one-shot, then re-armed by auto-reload
    wr(5'h00, 32'h0);
    wr(5'h10, 32'h2);
    wr(5'h14, 32'h2);
    wr(5'h00, 32'h1);
    run_cycles(8, 0, p);
    check("R5 single pulse", 32'(p), 32'd1);
    rd(5'h14, v); check("R5 parked at zero", v, 32'h0);
    wr(5'h00, 32'h3);
    run_cycles(1, 0, p);
    check("R5 rearm pulse", 32'(p), 32'd1);
    rd(5'h14, v); check("R5 rearm reload", v, 32'h2);

    // R7 load overrides decrement
    wr(5'h00, 32'h4);
    wr(5'h1C, 32'd100);
    rd(5'h1C, v); check("R7 load value", v, 32'd100);
    run_cycles(1, 1, p);
    rd(5'h1C, v); check("R7 next decrement", v, 32'd99);

    // R7 held write suppresses expiry
    wr(5'h00, 32'h0);
    wr(5'h18, 32'h0);
    wr(5'h1C, 32'h0);
    wr(5'h00, 32'hC);
    bus_addr = 5'h1C; bus_wdata = 32'h0; bus_wr = 1'b1;
    p = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (irq[1]) p++;
    end
    bus_wr = 1'b0;
    check("R7 suppressed pulses", 32'(p), 32'd0);
    @(negedge clk);
    check("R7 pulse after release", {31'd0, irq[1]}, 32'd1);

    // R10 independence
    wr(5'h00, 32'h0);
    wr(5'h14, 32'd50);
    wr(5'h00, 32'h1);
    wr(5'h18, 32'd5);
    wr(5'h1C, 32'd9);
    rd(5'h14, v); check("R10 timer0 unaffected", v, 32'd48);
    rd(5'h1C, v); check("R10 timer1 value", v, 32'd9);
    check("R10 timer1 quiet", {31'd0, irq[1]}, 32'd0);

    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule